// File: doc/BRIEF.md
# Port Change Interrupt and Wake Unit

This block watches an 8-bit input port and compares it with a reference value. The reference is captured each time the core reads the port. When the change source is enabled, any synchronized pin that differs from the reference sets a change flag. The unit also holds pending flags for five other interrupt sources: timer overflow, the external interrupt pin, conversion complete, PWM underflow and comparator change. Each of those arrives as a one-cycle event pulse.

The enabled pending flags are combined into one request, which is used in two ways:
- While the core reports that it is asleep, the request raises a wake signal.
- When global interrupts are enabled, the request produces a one-cycle request to branch to a fixed vector address, 0x006.

With global interrupts disabled, a wake-up only lets the core resume in-line, because no vector request is made. Firmware must read the port before it enables the change source, and it clears flags with masked writes.

Top module: `pcw_intr_unit`

## Requirements
- R1: After reset, `pend_o`, `wake_o`, `vec_req_o`, `vec_addr_o` and `port_val_o` are all zero.
- R2: `port_val_o` shows `pin_i` after two register stages. A pin value driven before a clock edge appears after the second edge, not after the first.
- R3: A cycle with `port_rd_i` high loads the reference with `port_val_o`. The change flag sets under both of these conditions:
  - it is enabled (`src_en_i` bit 1), and
  - any bit of `port_val_o` differs from the reference.
  
  The flag does not set while its enable is low, and it does not set in a cycle where `port_rd_i` is high.
- R4: Source bit positions are timer=0, port change=1, external pin=2, conversion=3, PWM=4, comparator=5. A high bit of `evt_i` at positions 0, 2, 3, 4 and 5 sets the same bit of `pend_o` at the next edge, whatever the enables. Bit 1 of `evt_i` has no effect.
- R5: A pending flag stays set until a cycle with `clr_we_i` high and the flag's `clr_mask_i` bit set. If a set and a clear fall in the same cycle, the flag stays set.
- R6: `wake_o` is high one cycle after `sleep_i` is high and at least one pending flag has its enable set. Pending flags whose enable is low never raise `wake_o`.
- R7: When `gie_i` is high and an enabled flag is pending:
  - `vec_req_o` is high for exactly one cycle, with `vec_addr_o` = 0x006 in that cycle. In every other cycle `vec_addr_o` is 0.
  - A further pulse needs the set of enabled pending flags to become empty first.
- R8: With `gie_i` low, a wake-up raises `wake_o` without any `vec_req_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 8 | Asynchronous port pins |
| port_rd_i | input | 1 | Port read strobe; loads the compare reference |
| port_val_o | output | 8 | Synchronized port value (read data) |
| evt_i | input | 6 | One-cycle event pulses per source (bit 1 unused) |
| src_en_i | input | 6 | Per-source enables |
| gie_i | input | 1 | Global interrupt enable |
| sleep_i | input | 1 | Core is asleep |
| clr_we_i | input | 1 | Flag-clear write strobe |
| clr_mask_i | input | 6 | Flags to clear on a clear write |
| pend_o | output | 6 | Pending flags |
| wake_o | output | 1 | Wake request to the sleeping core |
| vec_req_o | output | 1 | One-cycle branch-to-vector request |
| vec_addr_o | output | 12 | Vector address, valid with the request |

## Verification
Two pairs of functions can coincide in one cycle.

- **Set and clear of the same flag.** The bench drives an `evt_i` bit in the same cycle as a clear write whose mask covers that bit. It then checks that the flag is still set afterwards.
- **Port read and detected change.** The bench times a port read for the cycle in which a new synchronized pin value first differs from the old reference. It judges the result by `pend_o` bit 1 staying clear, because the read takes the new value as the reference instead of reporting it as a change.

// File: rtl/pcw_pkg.sv
package pcw_pkg;
  localparam int NUM_SRC = 6;
  localparam int SRC_TMR = 0;
  localparam int SRC_CHG = 1;
  localparam int SRC_EXT = 2;
  localparam int SRC_ADC = 3;
  localparam int SRC_PWM = 4;
  localparam int SRC_CMP = 5;
  typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/pcw_sync.sv
module pcw_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pcw_change_det.sv
module pcw_change_det #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] val_i,
  input  logic         rd_i,
  input  logic         en_i,
  output logic         chg_o
);
  logic [W-1:0] ref_q;
  logic [W-1:0] diff;

  always_ff @(posedge clk) begin
    if (rst)       ref_q <= '0;
    else if (rd_i) ref_q <= val_i;
  end

  assign diff  = val_i ^ ref_q;
  // A read absorbs the current value as the new reference.
  assign chg_o = en_i && !rd_i && (|diff);
endmodule

// File: rtl/pcw_flag_bank.sv
module pcw_flag_bank #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic         clr_we_i,
  input  logic [N-1:0] clr_mask_i,
  output logic [N-1:0] pend_o
);
  for (genvar k = 0; k < N; k++) begin : g_flag
    logic flag_q;
    logic clr;
    assign clr = clr_we_i && clr_mask_i[k];
    always_ff @(posedge clk) begin
      if (rst)           flag_q <= 1'b0;
      else if (set_i[k]) flag_q <= 1'b1;
      else if (clr)      flag_q <= 1'b0;
    end
    assign pend_o[k] = flag_q;
  end
endmodule

// File: rtl/pcw_arbiter.sv
module pcw_arbiter #(
  parameter int N                 = 6,
  parameter int VEC_W             = 12,
  parameter logic [VEC_W-1:0] VEC = 12'h006
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     pend_i,
  input  logic [N-1:0]     en_i,
  input  logic             gie_i,
  input  logic             sleep_i,
  output logic             wake_o,
  output logic             vec_req_o,
  output logic [VEC_W-1:0] vec_addr_o
);
  logic             any_act;
  logic             taken_q;
  logic             req_d;
  logic             wake_q;
  logic             req_q;
  logic [VEC_W-1:0] addr_q;

  assign any_act = |(pend_i & en_i);
  assign req_d   = gie_i && any_act && !taken_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      taken_q <= 1'b0;
      wake_q  <= 1'b0;
      req_q   <= 1'b0;
      addr_q  <= '0;
    end else begin
      taken_q <= any_act && (taken_q || req_d);
      wake_q  <= sleep_i && any_act;
      req_q   <= req_d;
      addr_q  <= req_d ? VEC : '0;
    end
  end

  assign wake_o     = wake_q;
  assign vec_req_o  = req_q;
  assign vec_addr_o = addr_q;
endmodule

// File: rtl/pcw_intr_unit.sv
module pcw_intr_unit
  import pcw_pkg::*;
#(
  parameter int PORT_W               = 8,
  parameter int SYNC_STAGES          = 2,
  parameter int VEC_W                = 12,
  parameter logic [VEC_W-1:0] VEC_ADDR = 12'h006
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PORT_W-1:0] pin_i,
  input  logic              port_rd_i,
  output logic [PORT_W-1:0] port_val_o,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic [NUM_SRC-1:0] src_en_i,
  input  logic              gie_i,
  input  logic              sleep_i,
  input  logic              clr_we_i,
  input  logic [NUM_SRC-1:0] clr_mask_i,
  output logic [NUM_SRC-1:0] pend_o,
  output logic              wake_o,
  output logic              vec_req_o,
  output logic [VEC_W-1:0]  vec_addr_o
);
  logic [PORT_W-1:0] port_sync;
  logic              chg_evt;
  src_vec_t          set_vec;

  pcw_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i(pin_i), .q_o(port_sync)
  );

  pcw_change_det #(.W(PORT_W)) u_chg (
    .clk(clk), .rst(rst), .val_i(port_sync), .rd_i(port_rd_i),
    .en_i(src_en_i[SRC_CHG]), .chg_o(chg_evt)
  );

  always_comb begin
    set_vec          = evt_i;
    set_vec[SRC_CHG] = chg_evt;
  end

  pcw_flag_bank #(.N(NUM_SRC)) u_flags (
    .clk(clk), .rst(rst), .set_i(set_vec), .clr_we_i(clr_we_i),
    .clr_mask_i(clr_mask_i), .pend_o(pend_o)
  );

  pcw_arbiter #(.N(NUM_SRC), .VEC_W(VEC_W), .VEC(VEC_ADDR)) u_arb (
    .clk(clk), .rst(rst), .pend_i(pend_o), .en_i(src_en_i), .gie_i(gie_i),
    .sleep_i(sleep_i), .wake_o(wake_o), .vec_req_o(vec_req_o),
    .vec_addr_o(vec_addr_o)
  );

  assign port_val_o = port_sync;
endmodule

// File: rtl/pcw_checks.sv
module pcw_checks #(
  parameter int NS                 = 6,
  parameter int VEC_W              = 12,
  parameter logic [VEC_W-1:0] VADDR = 12'h006
) (
  input logic             clk,
  input logic             rst,
  input logic [NS-1:0]    pend_o,
  input logic [NS-1:0]    src_en_i,
  input logic             clr_we_i,
  input logic             gie_i,
  input logic             sleep_i,
  input logic             wake_o,
  input logic             vec_req_o,
  input logic [VEC_W-1:0] vec_addr_o
);
  // R7: request lasts a single cycle
  p_vec_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    vec_req_o |=> !vec_req_o);
  // R7: address valid with request
  p_vec_addr_r7: assert property (@(posedge clk) disable iff (rst)
    vec_req_o |-> (vec_addr_o == VADDR));
  // R7: address zero without request
  p_addr_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !vec_req_o |-> (vec_addr_o == '0));
  // R8: no request without global enable
  p_vec_gie_r8: assert property (@(posedge clk) disable iff (rst)
    vec_req_o |-> $past(gie_i));
  // R6: wake only follows sleep with an enabled pending flag
  p_wake_cause_r6: assert property (@(posedge clk) disable iff (rst)
    wake_o |-> ($past(sleep_i) && $past(|(pend_o & src_en_i))));
  // R5: flags never drop without a clear write
  p_flag_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !clr_we_i |=> ((pend_o & $past(pend_o)) == $past(pend_o)));
endmodule

bind pcw_intr_unit pcw_checks #(.NS(pcw_pkg::NUM_SRC), .VEC_W(VEC_W), .VADDR(VEC_ADDR)) u_chk (
  .clk(clk), .rst(rst), .pend_o(pend_o), .src_en_i(src_en_i),
  .clr_we_i(clr_we_i), .gie_i(gie_i), .sleep_i(sleep_i), .wake_o(wake_o),
  .vec_req_o(vec_req_o), .vec_addr_o(vec_addr_o)
);

// File: tb/pcw_intr_unit_tb.sv
module pcw_intr_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  pin_i = '0;
  logic        port_rd_i = 1'b0;
  logic [7:0]  port_val_o;
  logic [5:0]  evt_i = '0;
  logic [5:0]  src_en_i = '0;
  logic        gie_i = 1'b0;
  logic        sleep_i = 1'b0;
  logic        clr_we_i = 1'b0;
  logic [5:0]  clr_mask_i = '0;
  logic [5:0]  pend_o;
  logic        wake_o;
  logic        vec_req_o;
  logic [11:0] vec_addr_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcw_intr_unit dut_i (
    .clk(clk), .rst(rst), .pin_i(pin_i), .port_rd_i(port_rd_i),
    .port_val_o(port_val_o), .evt_i(evt_i), .src_en_i(src_en_i),
    .gie_i(gie_i), .sleep_i(sleep_i), .clr_we_i(clr_we_i),
    .clr_mask_i(clr_mask_i), .pend_o(pend_o), .wake_o(wake_o),
    .vec_req_o(vec_req_o), .vec_addr_o(vec_addr_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_all();
    clr_we_i = 1'b1; clr_mask_i = 6'h3f; step(1);
    clr_we_i = 1'b0; clr_mask_i = '0;
  endtask

  task automatic port_read();
    port_rd_i = 1'b1; step(1); port_rd_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "pend", pend_o, 0);
    chk("R1", "wake", wake_o, 0);
    chk("R1", "vec_req", vec_req_o, 0);
    chk("R1", "vec_addr", vec_addr_o, 0);
    chk("R1", "port_val", port_val_o, 0);
  endtask

  task automatic t_sync();
    pin_i = 8'hA5; step(1);
    chk("R2", "port_val after one edge", port_val_o, 8'h00);
    step(1);
    chk("R2", "port_val after two edges", port_val_o, 8'hA5);
  endtask

  task automatic t_change();
    port_read();
    src_en_i = 6'b000010; step(2);
    chk("R3", "no flag when port equals reference", pend_o[1], 0);
    pin_i = 8'hAD; step(2);
    chk("R3", "flag not yet set", pend_o[1], 0);
    step(1);
    chk("R3", "change flag set", pend_o[1], 1);
    clear_all(); step(1);
    chk("R3", "stale reference still flags", pend_o[1], 1);
    src_en_i = '0; clear_all(); port_read();
    src_en_i = 6'b000010; step(2);
    chk("R3", "reload via read clears cause", pend_o[1], 0);
  endtask

  task automatic t_change_disabled();
    src_en_i = '0; pin_i = 8'h3C; step(5);
    chk("R3", "disabled change sets nothing", pend_o[1], 0);
    port_read();
  endtask

  task automatic t_read_collide();
    src_en_i = 6'b000010;
    pin_i = 8'h5A; step(2);
    port_rd_i = 1'b1; step(1); port_rd_i = 1'b0;
    step(3);
    chk("R3", "read in change cycle suppresses flag", pend_o[1], 0);
  endtask

  task automatic t_events();
    evt_i = 6'b111101; step(1); evt_i = '0;
    chk("R4", "event flags", pend_o, 6'b111101);
    clear_all();
    evt_i = 6'b000010; step(1); evt_i = '0; step(2);
    chk("R4", "evt bit1 ignored", pend_o, 0);
  endtask

  task automatic t_clear();
    evt_i = 6'b111101; step(1); evt_i = '0;
    clr_we_i = 1'b1; clr_mask_i = 6'b000101; step(1);
    clr_we_i = 1'b0; clr_mask_i = '0;
    chk("R5", "masked clear", pend_o, 6'b111000);
    step(4);
    chk("R5", "flags hold", pend_o, 6'b111000);
    clr_mask_i = 6'b001000; step(2);
    chk("R5", "mask without strobe no clear", pend_o, 6'b111000);
    clr_mask_i = '0;
    clear_all();
    evt_i = 6'b000001; clr_we_i = 1'b1; clr_mask_i = 6'b000001; step(1);
    evt_i = '0; clr_we_i = 1'b0; clr_mask_i = '0;
    chk("R5", "set wins over clear", pend_o[0], 1);
    clear_all();
  endtask

  task automatic t_wake();
    src_en_i = 6'b000001; gie_i = 1'b0; sleep_i = 1'b1;
    evt_i = 6'b000100; step(1); evt_i = '0; step(2);
    chk("R6", "disabled flag no wake", wake_o, 0);
    evt_i = 6'b000001; step(1); evt_i = '0;
    chk("R6", "wake not before flag registered", wake_o, 0);
    step(1);
    chk("R6", "wake raised", wake_o, 1);
    chk("R8", "no vector with gie low", vec_req_o, 0);
    step(2);
    chk("R8", "still no vector", vec_req_o, 0);
    sleep_i = 1'b0; clear_all(); step(1);
    chk("R6", "wake drops", wake_o, 0);
  endtask

  task automatic t_vector();
    src_en_i = 6'b000001; gie_i = 1'b1;
    evt_i = 6'b000001; step(1); evt_i = '0;
    chk("R7", "no request yet", vec_req_o, 0);
    step(1);
    chk("R7", "request pulse", vec_req_o, 1);
    chk("R7", "vector address", vec_addr_o, 12'h006);
    step(1);
    chk("R7", "pulse ends", vec_req_o, 0);
    chk("R7", "address idle", vec_addr_o, 0);
    step(3);
    chk("R7", "no repeat while pending", vec_req_o, 0);
    clear_all(); step(1);
    evt_i = 6'b000001; step(1); evt_i = '0; step(1);
    chk("R7", "new pulse after empty", vec_req_o, 1);
    gie_i = 1'b0; clear_all(); src_en_i = '0; step(2);
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    t_reset();
    t_sync();
    t_change();
    t_change_disabled();
    t_read_collide();
    src_en_i = '0; clear_all();
    t_events();
    t_clear();
    t_wake();
    t_vector();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule